// File: doc/BRIEF.md
# Velocity-Form PID Compensator with Counter PWM

This block closes a voltage-mode DC-DC converter loop in fixed point. A free-running period counter drives the PWM output. Each time the counter wraps, the block takes one ADC code of the sensed output voltage. It subtracts that code from a programmable reference code to form an error sample. It then runs an incremental three-term difference equation over the newest error and the two previous errors. The accumulated control value becomes the duty command for the next switching period.

The sampling rate equals the switching rate. The computed duty is held in a pending register and takes effect only at the following counter wrap, so the loop always carries exactly one period of delay between sampling and actuation. A single shared multiplier is stepped by a small state machine. In IDLE the machine waits for a wrap. On a wrap it captures the error and clears the sum, then moves to TERM_A, TERM_B and TERM_C, which add the a, b and c products one per cycle. ROUND moves to COMMIT, and COMMIT returns to IDLE. Every transition except the one out of IDLE is unconditional.

The three coefficients and the reference are plain inputs that software may change at any time. A new value is used from the next computation onward.

Top module: `pid_dpwm_ctrl`

## Requirements
- R1: At each counter wrap the error sample is captured as the signed difference reference code minus ADC code, where both codes are unsigned ADC_W-bit values.
- R2: The update is u[n] = clamp(u[n-1] + floor((a*e[n] + b*e[n-1] + c*e[n-2] + 2^(FRAC-1)) / 2^FRAC)). The coefficients are CW-bit two's complement numbers with FRAC fraction bits (16 bits and 10 fraction bits by default). The products are summed exactly before this single rounding step.
- R3: u is clamped to the range 0 to 2^DUTY_W-1, and the clamped value is what is stored. Integration in the saturating direction therefore stops, and a reversed error moves u off the limit on the very next update.
- R4: A duty computed from the sample taken at wrap k is applied from wrap k+1. The block therefore adds exactly one switching period of delay.
- R5: The applied duty changes only on the clock edge at which the period counter wraps. It is constant for the whole period.
- R6: Reset clears u and both stored error samples. The PWM output stays low until the first computed duty is loaded, which happens at the second wrap after reset.
- R7: The period is 2^DUTY_W clocks, and period_wrap is high for one clock at its last count. Within a period, pwm_out is high for exactly duty_q clocks, starting from the first clock of the period.
- R8: The computation started at a wrap is complete, with the machine back in IDLE, before the next wrap.
- R9: A step in the reference code during operation changes the error on the next sample and is followed by the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_code | input | ADC_W | Reference in ADC codes |
| adc_code | input | ADC_W | Sensed output voltage code, sampled at wrap |
| coef_a | input | CW | Coefficient on e[n], signed fixed point |
| coef_b | input | CW | Coefficient on e[n-1], signed fixed point |
| coef_c | input | CW | Coefficient on e[n-2], signed fixed point |
| period_wrap | output | 1 | One-clock pulse at the last count of each period (ADC sample strobe) |
| duty_q | output | DUTY_W | Duty applied in the current period |
| pwm_out | output | 1 | PWM drive |

## Verification
The bench keeps an integer model of the difference equation and compares every applied duty against it. It also counts the high clocks of pwm_out in every period. A long positive error drives u into the upper clamp, and a reversed error then follows. A design that keeps integrating past the clamp would stay pinned for several periods instead of moving off the limit at once. The sequence also pushes u down to zero, where a sign or clamp fault would wrap the duty to a large value. A closed loop around a simple integer plant steps the reference from 110 to 130. A sweep with mixed-sign errors then catches wrong history ordering, wrong rounding, and a duty applied one period early or late.

// File: rtl/pid_dpwm_pkg.sv
package pid_dpwm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TERM_A,
        S_TERM_B,
        S_TERM_C,
        S_ROUND,
        S_COMMIT
    } calc_state_e;

    typedef enum logic [1:0] {
        SEL_A,
        SEL_B,
        SEL_C
    } term_sel_e;

endpackage

// File: rtl/pid_err_hist.sv
module pid_err_hist
    import pid_dpwm_pkg::*;
#(
    parameter int ADC_W = 10,
    parameter int ERR_W = ADC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic                    shift,
    input  logic [ADC_W-1:0]        ref_code,
    input  logic [ADC_W-1:0]        adc_code,
    input  term_sel_e               sel,
    output logic signed [ERR_W-1:0] err_sel
);

    localparam int DEPTH = 3;

    logic signed [ERR_W-1:0] hist_q [DEPTH];
    logic signed [ERR_W-1:0] err_new;

    assign err_new = $signed({{(ERR_W-ADC_W){1'b0}}, ref_code})
                   - $signed({{(ERR_W-ADC_W){1'b0}}, adc_code});

    // slot 0 holds e[n], later slots the older samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q[0] <= '0;
        end else if (capture) begin
            hist_q[0] <= err_new;
        end
    end

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_age
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q[g] <= '0;
                end else if (shift) begin
                    hist_q[g] <= hist_q[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_A:   err_sel = hist_q[0];
            SEL_B:   err_sel = hist_q[1];
            SEL_C:   err_sel = hist_q[2];
            default: err_sel = '0;
        endcase
    end

endmodule

// File: rtl/pid_mac.sv
module pid_mac #(
    parameter int CW     = 16,
    parameter int ERR_W  = 11,
    parameter int FRAC   = 10,
    parameter int DUTY_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    accum,
    input  logic                    commit,
    input  logic signed [CW-1:0]    coef,
    input  logic signed [ERR_W-1:0] err,
    output logic [DUTY_W-1:0]       u_q
);

    localparam int PW = CW + ERR_W;
    localparam int AW = PW + 2;
    localparam int DW = AW - FRAC;
    localparam int UW = DW + 1;
    localparam logic signed [AW-1:0] RND_HALF = AW'(1) << (FRAC - 1);
    localparam logic signed [UW-1:0] U_TOP    = UW'((1 << DUTY_W) - 1);

    logic signed [AW-1:0] acc_q;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;
    logic signed [AW-1:0] rnd;
    logic signed [DW-1:0] delta;
    logic signed [UW-1:0] u_sum;
    logic [DUTY_W-1:0]    u_clamped;

    assign prod     = coef * err;
    assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
    assign rnd      = acc_q + RND_HALF;
    assign delta    = rnd[AW-1:FRAC];
    assign u_sum    = $signed({{(UW-DUTY_W){1'b0}}, u_q}) + $signed({delta[DW-1], delta});

    always_comb begin
        if (u_sum < 0) begin
            u_clamped = '0;
        end else if (u_sum > U_TOP) begin
            u_clamped = '1;
        end else begin
            u_clamped = u_sum[DUTY_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (accum) begin
            acc_q <= acc_q + prod_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q <= '0;
        end else if (commit) begin
            u_q <= u_clamped;
        end
    end

endmodule

// File: rtl/pid_dpwm_core.sv
module pid_dpwm_core #(
    parameter int DUTY_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_valid,
    input  logic [DUTY_W-1:0] pend_duty,
    output logic              wrap,
    output logic [DUTY_W-1:0] duty_q,
    output logic              loaded_q,
    output logic              pwm_out
);

    logic [DUTY_W-1:0] cnt_q;

    assign wrap = &cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q   <= '0;
            loaded_q <= 1'b0;
        end else if (wrap && pend_valid) begin
            duty_q   <= pend_duty;
            loaded_q <= 1'b1;
        end
    end

    assign pwm_out = loaded_q && (cnt_q < duty_q);

endmodule

// File: rtl/pid_dpwm_ctrl.sv
module pid_dpwm_ctrl
    import pid_dpwm_pkg::*;
#(
    parameter int ADC_W  = 10,
    parameter int CW     = 16,
    parameter int FRAC   = 10,
    parameter int DUTY_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADC_W-1:0]     ref_code,
    input  logic [ADC_W-1:0]     adc_code,
    input  logic signed [CW-1:0] coef_a,
    input  logic signed [CW-1:0] coef_b,
    input  logic signed [CW-1:0] coef_c,
    output logic                 period_wrap,
    output logic [DUTY_W-1:0]    duty_q,
    output logic                 pwm_out
);

    localparam int ERR_W = ADC_W + 1;

    calc_state_e state_q;
    calc_state_e state_d;

    logic                    capture;
    logic                    clear_acc;
    logic                    accum;
    logic                    commit;
    logic                    shift;
    term_sel_e               sel;
    logic signed [CW-1:0]    coef_sel;
    logic signed [ERR_W-1:0] err_sel;
    logic [DUTY_W-1:0]       u_val;
    logic                    result_valid_q;
    logic                    loaded;
    logic                    fsm_idle;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (period_wrap) state_d = S_TERM_A;
            S_TERM_A: state_d = S_TERM_B;
            S_TERM_B: state_d = S_TERM_C;
            S_TERM_C: state_d = S_ROUND;
            S_ROUND:  state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        capture   = 1'b0;
        clear_acc = 1'b0;
        accum     = 1'b0;
        commit    = 1'b0;
        shift     = 1'b0;
        sel       = SEL_A;
        unique case (state_q)
            S_IDLE: begin
                capture   = period_wrap;
                clear_acc = period_wrap;
            end
            S_TERM_A: begin
                accum = 1'b1;
                sel   = SEL_A;
            end
            S_TERM_B: begin
                accum = 1'b1;
                sel   = SEL_B;
            end
            S_TERM_C: begin
                accum = 1'b1;
                sel   = SEL_C;
            end
            S_ROUND:  commit = 1'b1;
            S_COMMIT: shift  = 1'b1;
            default: ;
        endcase
    end

    assign fsm_idle = (state_q == S_IDLE);

    always_comb begin
        unique case (sel)
            SEL_A:   coef_sel = coef_a;
            SEL_B:   coef_sel = coef_b;
            SEL_C:   coef_sel = coef_c;
            default: coef_sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_valid_q <= 1'b0;
        end else if (shift) begin
            result_valid_q <= 1'b1;
        end
    end

    pid_err_hist #(
        .ADC_W (ADC_W),
        .ERR_W (ERR_W)
    ) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .shift    (shift),
        .ref_code (ref_code),
        .adc_code (adc_code),
        .sel      (sel),
        .err_sel  (err_sel)
    );

    pid_mac #(
        .CW     (CW),
        .ERR_W  (ERR_W),
        .FRAC   (FRAC),
        .DUTY_W (DUTY_W)
    ) mac_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_acc),
        .accum  (accum),
        .commit (commit),
        .coef   (coef_sel),
        .err    (err_sel),
        .u_q    (u_val)
    );

    pid_dpwm_core #(
        .DUTY_W (DUTY_W)
    ) pwm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_valid (result_valid_q),
        .pend_duty  (u_val),
        .wrap       (period_wrap),
        .duty_q     (duty_q),
        .loaded_q   (loaded),
        .pwm_out    (pwm_out)
    );

endmodule

// File: rtl/pid_dpwm_chk.sv
module pid_dpwm_chk #(
    parameter int DUTY_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              period_wrap,
    input logic [DUTY_W-1:0] duty_q,
    input logic              pwm_out,
    input logic              loaded,
    input logic              fsm_idle
);

    AST_DUTY_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !period_wrap |=> $stable(duty_q)); // R5

    AST_DARK_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> !pwm_out); // R6

    AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> loaded); // R6

    AST_CALC_DONE_BY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        period_wrap |-> fsm_idle); // R8

    AST_WRAP_STARTS_CALC: assert property (@(posedge clk) disable iff (!rst_n)
        period_wrap |=> !fsm_idle); // R4

    AST_ZERO_DUTY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !pwm_out); // R7

    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_wrap |=> !period_wrap); // R7

endmodule

bind pid_dpwm_ctrl pid_dpwm_chk #(
    .DUTY_W (DUTY_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_wrap (period_wrap),
    .duty_q      (duty_q),
    .pwm_out     (pwm_out),
    .loaded      (loaded),
    .fsm_idle    (fsm_idle)
);

// File: tb/pid_dpwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module pid_dpwm_ctrl_tb_top;

    localparam int ADC_W  = 10;
    localparam int CW     = 16;
    localparam int FRAC   = 10;
    localparam int DUTY_W = 9;
    localparam int PERIOD = 1 << DUTY_W;
    localparam int UMAX   = PERIOD - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [ADC_W-1:0]     ref_code = '0;
    logic [ADC_W-1:0]     adc_code = '0;
    logic signed [CW-1:0] coef_a = '0;
    logic signed [CW-1:0] coef_b = '0;
    logic signed [CW-1:0] coef_c = '0;
    logic                 period_wrap;
    logic [DUTY_W-1:0]    duty_q;
    logic                 pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // bench model state
    int m_u = 0;
    int m_e1 = 0;
    int m_e2 = 0;
    int m_pend = 0;
    bit m_pend_ok = 1'b0;
    int plant = 0;

    always #2.5 clk = ~clk;

    pid_dpwm_ctrl #(
        .ADC_W (ADC_W),
        .CW    (CW),
        .FRAC  (FRAC),
        .DUTY_W(DUTY_W)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_code    (ref_code),
        .adc_code    (adc_code),
        .coef_a      (coef_a),
        .coef_b      (coef_b),
        .coef_c      (coef_c),
        .period_wrap (period_wrap),
        .duty_q      (duty_q),
        .pwm_out     (pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            finish_run();
        end
    end

    // Called at the falling edge where period_wrap is high; returns at the next such edge.
    task automatic run_period(input string req, input int rv, input int av,
                              input int ca, input int cb, input int cc);
        int e;
        longint sum;
        longint delta;
        int nu;
        int exp_duty;
        int hi;
        ref_code = ADC_W'(rv);
        adc_code = ADC_W'(av);
        coef_a   = CW'(ca);
        coef_b   = CW'(cb);
        coef_c   = CW'(cc);
        // R1 R2 R3: independent integer model of the update
        e     = rv - av;
        sum   = longint'(ca) * e + longint'(cb) * m_e1 + longint'(cc) * m_e2;
        delta = (sum + (longint'(1) << (FRAC - 1))) >>> FRAC;
        nu    = m_u + int'(delta);
        if (nu < 0) nu = 0;
        if (nu > UMAX) nu = UMAX;
        m_u  = nu;
        m_e2 = m_e1;
        m_e1 = e;
        // R4: the value loaded at this wrap is the previous computation
        exp_duty  = m_pend_ok ? m_pend : 0;
        m_pend    = nu;
        m_pend_ok = 1'b1;
        hi = 0;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (i == 0) check({req, " R4 R5 applied duty"}, int'(duty_q), exp_duty);
            if (i == PERIOD / 2) check({req, " R5 duty held mid-period"}, int'(duty_q), exp_duty);
            if (pwm_out) hi++;
        end
        check({req, " R7 pwm high count"}, hi, exp_duty);
        check({req, " R7 wrap at period end"}, int'(period_wrap), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state
        check("R6 duty after reset", int'(duty_q), 0);
        check("R6 pwm low after reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        while (period_wrap !== 1'b1) @(negedge clk);

        // R3: pure integrator, positive error into the top clamp
        for (int p = 0; p < 6; p++) run_period("R3 ramp up", 300, 100, 1024, 0, 0);
        check("R3 clamped at top", int'(duty_q), UMAX);
        // R3: reversed error must move off the clamp on the next update
        run_period("R3 reverse", 0, 150, 1024, 0, 0);
        run_period("R3 reverse", 0, 150, 1024, 0, 0);
        check("R3 anti-windup release", int'(duty_q), UMAX - 150);
        for (int p = 0; p < 5; p++) run_period("R3 ramp down", 0, 150, 1024, 0, 0);
        check("R3 clamped at zero", int'(duty_q), 0);

        // R2 R9: closed loop around an integer plant, reference stepped 110 -> 130
        plant = 0;
        for (int p = 0; p < 40; p++) begin
            plant = (3 * plant + int'(duty_q)) / 4;
            run_period("R2 R9 ref 110", 110, plant, 3482, -6298, 3000);
        end
        for (int p = 0; p < 40; p++) begin
            plant = (3 * plant + int'(duty_q)) / 4;
            run_period("R9 ref 130", 130, plant, 3482, -6298, 3000);
        end

        // R1 R2: sweep of mixed-sign errors with another coefficient set
        for (int p = 0; p < 40; p++) begin
            run_period("R1 R2 sweep", 120, 100 + ((p * 37) % 64), 700, -300, 50);
        end

        finish_run();
    end

endmodule